// File: doc/BRIEF.md
# SM4 Iterative Block Cipher Core

This core runs the 32-round SM4 block cipher on one 128-bit block at a time. It completes one round per clock, so a block takes 32 cycles. A pulse on `start_i` while the core is idle loads the block. The core then reads one 32-bit round key in each busy cycle. It addresses that key with `rk_idx_o`, which points into an external key register file. The file must return the key on `rk_i` combinationally, in the same cycle. When the last round ends, `done_o` pulses and `block_o` shows the result. The result stays on `block_o` until the next accepted start.

The byte substitution holds no stored SM4 table. Each byte first passes through a nibble-indexed affine map into the AES field. It then goes through an AES forward S-box, which the core computes as a GF(2^8) inverse followed by the AES affine step. A second nibble-indexed affine map brings the byte back. The core has no decrypt mode of its own. To decrypt, the key source supplies the same 32 round keys in reverse order.

Top module: `sm4_core`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0, `rk_idx_o` is 0 and `block_o` is all zeros.
- R2: A clock edge that samples `start_i` = 1 while `busy_o` = 0 accepts a block. In the next cycle `busy_o` is 1 and `rk_idx_o` is 0.
- R3: While busy, `rk_idx_o` goes up by exactly one per cycle, from 0 to 31. The key on `rk_i` in the cycle where `rk_idx_o` = i is used as round key i.
- R4: `done_o` is high for exactly one cycle. That cycle comes 32 cycles after the accept edge, and `busy_o` is 0 during it.
- R5: Round i (0..31) forms t = X(i+1) ^ X(i+2) ^ X(i+3) ^ rk(i) and substitutes each byte of t to give B. It then writes X(i+4) = X(i) ^ B ^ rol(B,2) ^ rol(B,10) ^ rol(B,18) ^ rol(B,24), and this new word replaces the oldest state word.
- R6: The substitution of a byte v is computed in three steps:
  - A pre-map: PL[v[3:0]] ^ PH[v[7:4]], with
    - PL = 01 07 72 74 E4 E2 97 91 57 51 24 22 B2 B4 C1 C7
    - PH = 00 A2 49 EB 09 AB 40 E2 12 B0 5B F9 1B B9 52 F0
  - The AES forward S-box.
  - A post-map: QL[y[3:0]] ^ QH[y[7:4]], with
    - QL = 34 08 9D A1 CE F2 67 5B 82 BE 2B 17 78 44 D1 ED
    - QH = 00 DC AF 73 DD 01 72 AE BF 63 10 CC 62 BE CD 11

  Each table is listed for indices 0 to 15. As a result, 0x00 maps to 0xD6 and 0x01 maps to 0x90.
- R7: The input words are X0 = `block_i[127:96]`, X1 = `[95:64]`, X2 = `[63:32]` and X3 = `[31:0]`, so byte 0 is the most significant. The output is {X35, X34, X33, X32}. With the round keys of key 0123456789ABCDEFFEDCBA9876543210, the block 0123456789ABCDEFFEDCBA9876543210 gives 681EDF34D206965E86B3E94F536E4246.
- R8: Feeding a result back in with the round keys in reverse order (rk31 first) returns the original block.
- R9: While busy, `start_i` has no effect. The running block completes with an unchanged result and unchanged timing.
- R10: While idle, `block_o` holds its value until the next accepted start, whatever `block_i` and `rk_i` do.
- R11: A start in the cycle where `done_o` is high is accepted, so blocks can run back to back without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a block when the core is idle |
| block_i | input | 128 | Input block, sampled on the accept edge |
| rk_i | input | 32 | Round key addressed by `rk_idx_o` |
| rk_idx_o | output | 5 | Index of the round key used in this cycle |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| block_o | output | 128 | Result, held while idle |

## Verification
The assertions assume only that reset is applied before the first start. `start_i` may arrive in any cycle. The hold check assumes that no start arrives in the cycle it observes. The bench drives the key source as a combinational lookup indexed by `rk_idx_o`, which is what the index check relies on. It deliberately pulses `start_i` in the middle of a run and in the `done_o` cycle, to cover the ignored start (R9) and the back-to-back start (R11).

// File: rtl/sm4_pkg.sv
package sm4_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int BLOCK_W = 128;
  localparam int NWORDS  = BLOCK_W / WORD_W;
  localparam int NBYTES  = WORD_W / BYTE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t PRE_LO [16] = '{8'h01, 8'h07, 8'h72, 8'h74, 8'hE4, 8'hE2, 8'h97, 8'h91,
                                    8'h57, 8'h51, 8'h24, 8'h22, 8'hB2, 8'hB4, 8'hC1, 8'hC7};
  localparam byte_t PRE_HI [16] = '{8'h00, 8'hA2, 8'h49, 8'hEB, 8'h09, 8'hAB, 8'h40, 8'hE2,
                                    8'h12, 8'hB0, 8'h5B, 8'hF9, 8'h1B, 8'hB9, 8'h52, 8'hF0};
  localparam byte_t PST_LO [16] = '{8'h34, 8'h08, 8'h9D, 8'hA1, 8'hCE, 8'hF2, 8'h67, 8'h5B,
                                    8'h82, 8'hBE, 8'h2B, 8'h17, 8'h78, 8'h44, 8'hD1, 8'hED};
  localparam byte_t PST_HI [16] = '{8'h00, 8'hDC, 8'hAF, 8'h73, 8'hDD, 8'h01, 8'h72, 8'hAE,
                                    8'hBF, 8'h63, 8'h10, 8'hCC, 8'h62, 8'hBE, 8'hCD, 8'h11};

  function automatic word_t rol32(input word_t v, input int k);
    return (v << k) | (v >> (WORD_W - k));
  endfunction

  function automatic byte_t rol8(input byte_t v, input int k);
    return (v << k) | (v >> (BYTE_W - k));
  endfunction

  // multiplication in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t p;
    byte_t s;
    p = '0;
    s = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p = p ^ s;
      s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  // a^254 == a^-1 (0 maps to 0)
  function automatic byte_t gf_inv(input byte_t a);
    byte_t a2, a3, a12, a15, a240;
    a2   = gf_mul(a, a);
    a3   = gf_mul(a2, a);
    a12  = gf_mul(gf_mul(a3, a3), gf_mul(a3, a3));
    a15  = gf_mul(a12, a3);
    a240 = gf_mul(a15, a15);
    a240 = gf_mul(a240, a240);
    a240 = gf_mul(a240, a240);
    a240 = gf_mul(a240, a240);
    return gf_mul(gf_mul(a240, a12), a2);
  endfunction

  function automatic byte_t aes_affine(input byte_t b);
    return b ^ rol8(b, 1) ^ rol8(b, 2) ^ rol8(b, 3) ^ rol8(b, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/sm4_sbox.sv
module sm4_sbox
  import sm4_pkg::*;
(
  input  byte_t a_i,
  output byte_t s_o
);
  byte_t fwd_q;
  byte_t aes_y;

  always_comb begin
    fwd_q = PRE_LO[a_i[3:0]] ^ PRE_HI[a_i[7:4]];
    aes_y = aes_affine(gf_inv(fwd_q));
    s_o   = PST_LO[aes_y[3:0]] ^ PST_HI[aes_y[7:4]];
  end
endmodule

// File: rtl/sm4_round.sv
module sm4_round
  import sm4_pkg::*;
(
  input  word_t t_i,
  output word_t f_o
);
  word_t sub;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    sm4_sbox u_sbox (
      .a_i (t_i[b*BYTE_W +: BYTE_W]),
      .s_o (sub[b*BYTE_W +: BYTE_W])
    );
  end

  assign f_o = sub ^ rol32(sub, 2) ^ rol32(sub, 10) ^ rol32(sub, 18) ^ rol32(sub, 24);
endmodule

// File: rtl/sm4_seq.sv
module sm4_seq #(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;
  logic             last;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last   = busy_q && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= last;
      if (load_o) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/sm4_state.sv
module sm4_state
  import sm4_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [BLOCK_W-1:0] block_i,
  input  word_t              rk_i,
  output logic [BLOCK_W-1:0] block_o
);
  word_t x_q [NWORDS];
  word_t t, f;

  assign t = x_q[1] ^ x_q[2] ^ x_q[3] ^ rk_i;

  sm4_round u_round (
    .t_i (t),
    .f_o (f)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NWORDS; w++) x_q[w] <= '0;
    end else if (load_i) begin
      for (int w = 0; w < NWORDS; w++) x_q[w] <= block_i[BLOCK_W-1-w*WORD_W -: WORD_W];
    end else if (step_i) begin
      for (int w = 0; w < NWORDS-1; w++) x_q[w] <= x_q[w+1];
      x_q[NWORDS-1] <= x_q[0] ^ f;
    end
  end

  // reversed word order on output
  for (genvar w = 0; w < NWORDS; w++) begin : g_out
    assign block_o[w*WORD_W +: WORD_W] = x_q[w];
  end
endmodule

// File: rtl/sm4_core.sv
module sm4_core
  import sm4_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [BLOCK_W-1:0] block_i,
  input  logic [WORD_W-1:0]  rk_i,
  output logic [IDX_W-1:0]   rk_idx_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [BLOCK_W-1:0] block_o
);
  logic load, step;

  sm4_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .idx_o   (rk_idx_o)
  );

  sm4_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .block_i (block_i),
    .rk_i    (rk_i),
    .block_o (block_o)
  );
endmodule

// File: rtl/sm4_core_checker.sv
module sm4_core_checker #(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [IDX_W-1:0] rk_idx_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [127:0]     block_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && rk_idx_o == '0));

  assert_idx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rk_idx_o != LAST) |=> (busy_o && rk_idx_o == IDX_W'($past(rk_idx_o) + 1'b1)));

  assert_done_after_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rk_idx_o == LAST) |=> (done_o && !busy_o));

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_ignore_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && rk_idx_o != LAST) |=> (rk_idx_o == IDX_W'($past(rk_idx_o) + 1'b1)));

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(block_o));
endmodule

bind sm4_core sm4_core_checker #(.ROUNDS(ROUNDS)) u_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .rk_idx_o (rk_idx_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .block_o  (block_o)
);

// File: tb/sm4_core_test.sv
module sm4_core_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] block_i = '0;
  logic [31:0]  rk_i;
  logic [4:0]   rk_idx_o;
  logic         busy_o, done_o;
  logic [127:0] block_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] rk_tab [32];
  bit          dec_mode = 1'b0;

  always #5 clk = ~clk;

  sm4_core uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .block_i  (block_i),
    .rk_i     (rk_i),
    .rk_idx_o (rk_idx_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .block_o  (block_o)
  );

  always_comb rk_i = dec_mode ? rk_tab[31 - int'(rk_idx_o)] : rk_tab[rk_idx_o];

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_aes(input logic [7:0] v);
    logic [7:0] inv = '0;
    logic [7:0] r;
    for (int c = 1; c < 256; c++) if (m_mul(v, 8'(c)) == 8'h01) inv = 8'(c);
    r = 8'h63;
    for (int k = 0; k < 5; k++) r = r ^ ((inv << k) | (inv >> (8 - k)));
    return r;
  endfunction

  logic [7:0] m_sb [256];

  function automatic logic [7:0] m_build(input logic [7:0] v);
    logic [7:0] pl [16] = '{8'h01,8'h07,8'h72,8'h74,8'hE4,8'hE2,8'h97,8'h91,8'h57,8'h51,8'h24,8'h22,8'hB2,8'hB4,8'hC1,8'hC7};
    logic [7:0] ph [16] = '{8'h00,8'hA2,8'h49,8'hEB,8'h09,8'hAB,8'h40,8'hE2,8'h12,8'hB0,8'h5B,8'hF9,8'h1B,8'hB9,8'h52,8'hF0};
    logic [7:0] ql [16] = '{8'h34,8'h08,8'h9D,8'hA1,8'hCE,8'hF2,8'h67,8'h5B,8'h82,8'hBE,8'h2B,8'h17,8'h78,8'h44,8'hD1,8'hED};
    logic [7:0] qh [16] = '{8'h00,8'hDC,8'hAF,8'h73,8'hDD,8'h01,8'h72,8'hAE,8'hBF,8'h63,8'h10,8'hCC,8'h62,8'hBE,8'hCD,8'h11};
    logic [7:0] y;
    y = m_aes(pl[v[3:0]] ^ ph[v[7:4]]);
    return ql[y[3:0]] ^ qh[y[7:4]];
  endfunction

  function automatic logic [31:0] m_rot(input logic [31:0] v, input int k);
    return (v << k) | (v >> (32 - k));
  endfunction

  function automatic logic [31:0] m_tau(input logic [31:0] v);
    return {m_sb[v[31:24]], m_sb[v[23:16]], m_sb[v[15:8]], m_sb[v[7:0]]};
  endfunction

  task automatic expand_key(input logic [127:0] mk);
    logic [31:0] k [36];
    logic [31:0] fk [4] = '{32'hA3B1BAC6, 32'h56AA3350, 32'h677D9197, 32'hB27022DC};
    logic [31:0] ck, b;
    for (int i = 0; i < 4; i++) k[i] = mk[127 - 32*i -: 32] ^ fk[i];
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 4; j++) ck[31 - 8*j -: 8] = 8'(((4*i + j) * 7) % 256);
      b = m_tau(k[i+1] ^ k[i+2] ^ k[i+3] ^ ck);
      k[i+4] = k[i] ^ b ^ m_rot(b, 13) ^ m_rot(b, 23);
      rk_tab[i] = k[i+4];
    end
  endtask

  function automatic logic [127:0] m_crypt(input logic [127:0] blk, input bit dec);
    logic [31:0] x [4];
    logic [31:0] b, nw;
    for (int i = 0; i < 4; i++) x[i] = blk[127 - 32*i -: 32];
    for (int i = 0; i < 32; i++) begin
      b  = m_tau(x[1] ^ x[2] ^ x[3] ^ (dec ? rk_tab[31-i] : rk_tab[i]));
      nw = x[0] ^ b ^ m_rot(b, 2) ^ m_rot(b, 10) ^ m_rot(b, 18) ^ m_rot(b, 24);
      x[0] = x[1]; x[1] = x[2]; x[2] = x[3]; x[3] = nw;
    end
    return {x[3], x[2], x[1], x[0]};
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // caller sits at a negedge; start is driven there
  task automatic run_block(input logic [127:0] pt, input bit dec, input int poke_at,
                           output logic [127:0] ct, output int lat, output bit idx_ok);
    dec_mode = dec;
    block_i  = pt;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    block_i  = ~pt;
    lat      = 0;
    idx_ok   = 1'b1;
    while (!done_o && lat < 100) begin
      if (!busy_o || rk_idx_o != 5'(lat)) idx_ok = 1'b0;
      if (lat == poke_at) begin
        start_i = 1'b1;
        block_i = rnd128();
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    ct = block_o;
  endtask

  // ---------------- scenarios ----------------
  task automatic test_reset();
    check(busy_o == 1'b0, "R1 busy", 128'(busy_o), 128'h0);
    check(done_o == 1'b0, "R1 done", 128'(done_o), 128'h0);
    check(rk_idx_o == 5'd0, "R1 idx", 128'(rk_idx_o), 128'h0);
    check(block_o == '0, "R1 block", block_o, 128'h0);
  endtask

  task automatic test_standard();
    logic [127:0] v = 128'h0123456789ABCDEFFEDCBA9876543210;
    logic [127:0] ct, pt;
    int lat;
    bit ok;
    check(m_sb[8'h00] == 8'hD6 && m_sb[8'h01] == 8'h90, "R6 model sbox",
          128'({m_sb[8'h00], m_sb[8'h01]}), 128'hD690);
    expand_key(v);
    run_block(v, 1'b0, -1, ct, lat, ok);
    check(ct == 128'h681EDF34D206965E86B3E94F536E4246, "R7 standard vector", ct,
          128'h681EDF34D206965E86B3E94F536E4246);
    check(lat == 32, "R4 latency", 128'(lat), 128'd32);
    check(ok, "R2 R3 index sequence", 128'(ok), 128'd1);
    check(done_o && !busy_o, "R4 done idle", 128'({done_o, busy_o}), 128'b10);
    @(negedge clk);
    check(!done_o, "R4 single pulse", 128'(done_o), 128'd0);
    run_block(ct, 1'b1, -1, pt, lat, ok);
    check(pt == v, "R8 decrypt standard", pt, v);
  endtask

  task automatic test_random();
    logic [127:0] pt, ct, back;
    int lat;
    bit ok;
    for (int n = 0; n < 4; n++) begin
      expand_key(rnd128());
      pt = (n == 0) ? '0 : (n == 1) ? '1 : rnd128();
      run_block(pt, 1'b0, -1, ct, lat, ok);
      check(ct == m_crypt(pt, 1'b0), "R5 R6 random encrypt", ct, m_crypt(pt, 1'b0));
      @(negedge clk);
      run_block(ct, 1'b1, -1, back, lat, ok);
      check(back == pt, "R8 random decrypt", back, pt);
      @(negedge clk);
    end
  endtask

  task automatic test_busy_start();
    logic [127:0] pt = rnd128();
    logic [127:0] ct;
    int lat;
    bit ok;
    run_block(pt, 1'b0, 10, ct, lat, ok);
    check(ct == m_crypt(pt, 1'b0), "R9 result with start while busy", ct, m_crypt(pt, 1'b0));
    check(lat == 32 && ok, "R9 timing with start while busy", 128'(lat), 128'd32);
  endtask

  task automatic test_hold();
    logic [127:0] snap;
    @(negedge clk);
    snap = block_o;
    for (int i = 0; i < 6; i++) begin
      block_i  = rnd128();
      dec_mode = ~dec_mode;
      @(negedge clk);
    end
    dec_mode = 1'b0;
    check(block_o == snap && !busy_o, "R10 hold while idle", block_o, snap);
  endtask

  task automatic test_back_to_back();
    logic [127:0] a = rnd128();
    logic [127:0] b = rnd128();
    logic [127:0] ca, cb;
    int lat;
    bit ok;
    run_block(a, 1'b0, -1, ca, lat, ok);
    check(ca == m_crypt(a, 1'b0), "R11 first block", ca, m_crypt(a, 1'b0));
    run_block(b, 1'b0, -1, cb, lat, ok);
    check(cb == m_crypt(b, 1'b0) && lat == 32 && ok, "R11 second block", cb, m_crypt(b, 1'b0));
  endtask

  initial begin
    for (int v = 0; v < 256; v++) m_sb[v] = m_build(8'(v));
    for (int i = 0; i < 32; i++) rk_tab[i] = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_standard();
    @(negedge clk);
    test_random();
    test_busy_start();
    test_hold();
    test_back_to_back();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule